// File: doc/BRIEF.md
# Posted write ingress controller

This block is the receiving front end of a bus bridge. An external initiator opens a write with an address strobe and then streams data beats. The block stores the beats in a local synchronous FIFO and posts the write: the initiator's transaction finishes before any downstream write happens. When the burst ends, or the FIFO fills, the block hands the buffered words to a downstream drain engine with a one-cycle commit pulse that carries the start address and the word count. The drain engine then pops the FIFO through a show-ahead read port.

Only one posted write may be outstanding at a time. A new address strobe is refused with a retry (a disconnect without data) while any of these holds: the FIFO still holds words, the drain engine reports busy, or the drain engine is repeating a rearbitrated write. A system error or a data parity error during a data beat stops the burst and flushes what was buffered. A parity error also sends an abort to the drain engine. Each error condition sets a sticky flag. A partial byte enable inside a multi-beat burst also sets a sticky flag. All flags are cleared through a write-one-to-clear input.

Top module: `posted_write_ingress`

## Requirements
- R1: After reset `fifo_empty` is 1 and `tgt_retry`, `tgt_stop`, `commit`, `drain_abort` and `irq_flags` are all 0.
- R2: After an accepted `in_start`, each `in_valid` beat is written to the FIFO. The cycle after the beat with `in_last`, `commit` pulses for one cycle, `commit_addr` holds the address captured with `in_start`, `commit_words` holds the number of beats written, and `tgt_stop` is 0.
- R3: When a beat without `in_last` brings the burst to DEPTH words, the next cycle shows `commit` with `commit_words` = DEPTH and `tgt_stop` = 1. A DEPTH-th beat that carries `in_last` commits with `tgt_stop` = 0.
- R4: An `in_start` that arrives while the FIFO is non-empty or `drain_busy` is 1 gives `tgt_retry` = 1 in the next cycle. It writes nothing, and the beats that follow it are ignored.
- R5: An `in_start` that arrives while `drain_rearb` is 1 is refused with `tgt_retry`, even when the FIFO is empty.
- R6: A beat with `in_valid` and `in_serr` during a burst is not written. In the next cycle `tgt_stop` is 1, `commit` is 0, the FIFO is empty and `irq_flags[0]` is set. The next `in_start` is accepted.
- R7: A beat with `in_valid` and `in_perr` (and no `in_serr`) during a burst is not written. In the next cycle `tgt_stop` is 1, `drain_abort` pulses, the FIFO is empty and `irq_flags[1]` is set.
- R8: A written beat whose `in_be` is not all ones sets `irq_flags[2]`, unless it is the first and last beat of its burst. The data is still stored as a full word.
- R9: Writing 1 to a bit of `irq_clr` clears that flag in the next cycle. Other flags are left unchanged. A set in the same cycle wins over a clear.
- R10: `rd_data` shows the oldest stored word while `fifo_empty` is 0. Each `rd_en` cycle pops one word, so words leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_start | input | 1 | Initiator opens a write (address phase) |
| in_addr | input | AW | Start address of the write |
| in_valid | input | 1 | Data beat present |
| in_data | input | DW | Beat data |
| in_be | input | DW/8 | Beat byte enables |
| in_last | input | 1 | Final beat of the burst |
| in_serr | input | 1 | System error during this beat |
| in_perr | input | 1 | Parity error detected on this beat |
| tgt_retry | output | 1 | Disconnect without data, write refused |
| tgt_stop | output | 1 | Disconnect: burst cut by a full FIFO or an error |
| drain_busy | input | 1 | Drain engine still writing downstream |
| drain_rearb | input | 1 | Drain engine repeating a rearbitrated write |
| commit | output | 1 | Buffered write handed to the drain engine |
| commit_addr | output | AW | Start address of the committed write |
| commit_words | output | clog2(DEPTH+1) | Number of committed words |
| drain_abort | output | 1 | Drain engine must terminate as soon as possible |
| rd_en | input | 1 | Pop one FIFO word |
| rd_data | output | DW | Oldest FIFO word |
| fifo_empty | output | 1 | FIFO holds no words |
| irq_clr | input | 3 | Write-one-to-clear for the flags |
| irq_flags | output | 3 | Sticky flags: [0] system error, [1] parity error, [2] byte-enable violation |

## Verification
The hardest state to reach is a cut burst that lands on an exact boundary. Examples are a burst whose DEPTH-th beat also carries `in_last`, or an error on the very beat that would have filled the FIFO. There the fill commit, the normal end and the error flush all compete for the same edge. Directed bursts of exactly DEPTH and DEPTH+4 beats cover the fill cases. Seeded random bursts of 1 to DEPTH+4 beats, with an error or a partial byte enable placed on a random beat, reach the error-at-fill and first-beat cases. The set-versus-clear race on a flag is forced by holding `irq_clr` high during the beat that carries the error.

// File: rtl/pwi_pkg.sv
package pwi_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_DATA = 1'b1
  } pwi_state_e;

  localparam int IRQ_SERR = 0;
  localparam int IRQ_PERR = 1;
  localparam int IRQ_BEV  = 2;
  localparam int IRQ_N    = 3;
endpackage

// File: rtl/pwi_fifo.sv
module pwi_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW:0]   wptr_q, wptr_d, rptr_q, rptr_d;
  logic          full;
  logic          do_wr, do_rd;

  assign empty   = (wptr_q == rptr_q);
  assign full    = (wptr_q[PW] != rptr_q[PW]) && (wptr_q[PW-1:0] == rptr_q[PW-1:0]);
  assign rd_data = mem[rptr_q[PW-1:0]];
  assign do_wr   = wr_en && !full && !flush;
  assign do_rd   = rd_en && !empty && !flush;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
    end else begin
      if (do_wr) wptr_d = wptr_q + 1'b1;
      if (do_rd) rptr_d = rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr_q[PW-1:0]] <= wr_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full); // R3
  AST_POP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd && !do_wr) |=> (rptr_q == $past(rptr_q) + 1'b1)); // R10
endmodule

// File: rtl/pwi_irq.sv
module pwi_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      logic flag_q, flag_d;
      always_comb flag_d = set[i] | (flag_q & ~clr[i]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
      end
      assign flags[i] = flag_q;

      AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !set[i]) |=> !flags[i]); // R9
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set[i] |=> flags[i]); // R9
    end
  endgenerate
endmodule

// File: rtl/pwi_ctrl.sv
module pwi_ctrl
  import pwi_pkg::*;
#(
  parameter int AW    = 32,
  parameter int BEW   = 4,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_start,
  input  logic [AW-1:0]  in_addr,
  input  logic           in_valid,
  input  logic [BEW-1:0] in_be,
  input  logic           in_last,
  input  logic           in_serr,
  input  logic           in_perr,
  input  logic           fifo_empty,
  input  logic           drain_busy,
  input  logic           drain_rearb,
  output logic           fifo_wr,
  output logic           fifo_flush,
  output logic           tgt_retry,
  output logic           tgt_stop,
  output logic           commit,
  output logic [AW-1:0]  commit_addr,
  output logic [CW-1:0]  commit_words,
  output logic           drain_abort,
  output logic [IRQ_N-1:0] irq_set
);
  pwi_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          retry_q, retry_d;
  logic          stop_q, stop_d;
  logic          commit_q, commit_d;
  logic          abort_q, abort_d;
  logic [AW-1:0] caddr_q;
  logic [CW-1:0] cwords_q;
  logic          busy;
  logic          fills;

  assign busy    = drain_busy | drain_rearb | ~fifo_empty;
  assign cnt_inc = cnt_q + CW'(1);
  assign fills   = (cnt_q == CW'(DEPTH - 1));

  always_comb begin
    state_d    = state_q;
    addr_d     = addr_q;
    cnt_d      = cnt_q;
    retry_d    = 1'b0;
    stop_d     = 1'b0;
    commit_d   = 1'b0;
    abort_d    = 1'b0;
    fifo_wr    = 1'b0;
    fifo_flush = 1'b0;
    irq_set    = '0;
    case (state_q)
      ST_IDLE: begin
        if (in_start) begin
          if (busy) begin
            retry_d = 1'b1;
          end else begin
            state_d = ST_DATA;
            addr_d  = in_addr;
            cnt_d   = '0;
          end
        end
      end
      ST_DATA: begin
        if (in_valid) begin
          if (in_serr) begin
            fifo_flush        = 1'b1;
            stop_d            = 1'b1;
            irq_set[IRQ_SERR] = 1'b1;
            state_d           = ST_IDLE;
          end else if (in_perr) begin
            fifo_flush        = 1'b1;
            stop_d            = 1'b1;
            abort_d           = 1'b1;
            irq_set[IRQ_PERR] = 1'b1;
            state_d           = ST_IDLE;
          end else begin
            fifo_wr = 1'b1;
            cnt_d   = cnt_inc;
            if ((in_be != '1) && !((cnt_q == '0) && in_last))
              irq_set[IRQ_BEV] = 1'b1;
            if (in_last || fills) begin
              commit_d = 1'b1;
              stop_d   = !in_last;
              state_d  = ST_IDLE;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      cnt_q    <= '0;
      retry_q  <= 1'b0;
      stop_q   <= 1'b0;
      commit_q <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      addr_q   <= addr_d;
      cnt_q    <= cnt_d;
      retry_q  <= retry_d;
      stop_q   <= stop_d;
      commit_q <= commit_d;
      abort_q  <= abort_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      caddr_q  <= '0;
      cwords_q <= '0;
    end else if (commit_d) begin
      caddr_q  <= addr_q;
      cwords_q <= cnt_inc;
    end
  end

  assign tgt_retry    = retry_q;
  assign tgt_stop     = stop_q;
  assign commit       = commit_q;
  assign commit_addr  = caddr_q;
  assign commit_words = cwords_q;
  assign drain_abort  = abort_q;

  AST_RETRY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && in_start && (drain_busy || !fifo_empty))
      |=> (tgt_retry && state_q == ST_IDLE)); // R4
  AST_RETRY_REARB: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && in_start && drain_rearb) |=> tgt_retry); // R5
  AST_ERR_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && in_valid && (in_serr || in_perr))
      |=> (tgt_stop && !commit && fifo_empty)); // R6
  AST_COMMIT_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (commit_words != '0 && commit_words <= CW'(DEPTH))); // R2
  AST_FILL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && commit_words < CW'(DEPTH)) |-> !tgt_stop); // R3
endmodule

// File: rtl/posted_write_ingress.sv
module posted_write_ingress
  import pwi_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_start,
  input  logic [AW-1:0]              in_addr,
  input  logic                       in_valid,
  input  logic [DW-1:0]              in_data,
  input  logic [DW/8-1:0]            in_be,
  input  logic                       in_last,
  input  logic                       in_serr,
  input  logic                       in_perr,
  output logic                       tgt_retry,
  output logic                       tgt_stop,
  input  logic                       drain_busy,
  input  logic                       drain_rearb,
  output logic                       commit,
  output logic [AW-1:0]              commit_addr,
  output logic [$clog2(DEPTH+1)-1:0] commit_words,
  output logic                       drain_abort,
  input  logic                       rd_en,
  output logic [DW-1:0]              rd_data,
  output logic                       fifo_empty,
  input  logic [2:0]                 irq_clr,
  output logic [2:0]                 irq_flags
);
  localparam int BEW = DW / 8;

  logic             fifo_wr;
  logic             fifo_flush;
  logic [IRQ_N-1:0] irq_set;

  pwi_ctrl #(.AW(AW), .BEW(BEW), .DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_start     (in_start),
    .in_addr      (in_addr),
    .in_valid     (in_valid),
    .in_be        (in_be),
    .in_last      (in_last),
    .in_serr      (in_serr),
    .in_perr      (in_perr),
    .fifo_empty   (fifo_empty),
    .drain_busy   (drain_busy),
    .drain_rearb  (drain_rearb),
    .fifo_wr      (fifo_wr),
    .fifo_flush   (fifo_flush),
    .tgt_retry    (tgt_retry),
    .tgt_stop     (tgt_stop),
    .commit       (commit),
    .commit_addr  (commit_addr),
    .commit_words (commit_words),
    .drain_abort  (drain_abort),
    .irq_set      (irq_set)
  );

  pwi_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (fifo_flush),
    .wr_en   (fifo_wr),
    .wr_data (in_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .empty   (fifo_empty)
  );

  pwi_irq #(.N(IRQ_N)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (irq_set),
    .clr   (irq_clr),
    .flags (irq_flags)
  );

  AST_ABORT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    drain_abort |-> (fifo_empty && tgt_stop && irq_flags[IRQ_PERR])); // R7
  AST_SERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_stop && !commit && !drain_abort) |-> irq_flags[IRQ_SERR]); // R6
endmodule

// File: tb/sim_posted_write_ingress.sv
`timescale 1ns/1ps
module sim_posted_write_ingress;
  localparam int AW = 32, DW = 32, DEPTH = 8, CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic in_start, in_valid, in_last, in_serr, in_perr;
  logic [AW-1:0] in_addr;
  logic [DW-1:0] in_data;
  logic [DW/8-1:0] in_be;
  logic tgt_retry, tgt_stop, drain_busy, drain_rearb, commit, drain_abort;
  logic [AW-1:0] commit_addr;
  logic [CW-1:0] commit_words;
  logic rd_en, fifo_empty;
  logic [DW-1:0] rd_data;
  logic [2:0] irq_clr, irq_flags;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [2:0] exp_irq = 3'b000;
  logic [DW-1:0] sent [DEPTH];
  logic [2:0] beat_clr = 3'b000;

  always #2 clk = ~clk;

  posted_write_ingress #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] bev_expect(input int i, input int len, input int part_at);
    return (i == part_at && !(i == 0 && len == 1)) ? 3'b100 : 3'b000;
  endfunction

  task automatic start_req(input logic [AW-1:0] a, input bit exp_retry, input string req);
    @(negedge clk);
    in_start = 1'b1; in_addr = a;
    @(negedge clk);
    in_start = 1'b0;
    chk(tgt_retry == exp_retry, req, 64'(tgt_retry), 64'(exp_retry));
  endtask

  // kind: 0 none, 1 system error, 2 parity error at beat err_at
  task automatic run_burst(input logic [AW-1:0] a, input int len, input int err_at, input int kind,
                           input int part_at, output int words);
    bit fin = 0;
    int n = 0;
    words = 0;
    start_req(a, 1'b0, "R4");
    for (int i = 0; i < len && !fin; i++) begin
      bit lst = (i == len - 1);
      bit is_err = (kind != 0) && (i == err_at);
      logic [DW-1:0] d = $urandom;
      in_valid = 1'b1; in_data = d; in_last = lst;
      in_be = (i == part_at) ? 4'b0101 : 4'hF;
      in_serr = is_err && kind == 1;
      in_perr = is_err && kind == 2;
      irq_clr = is_err ? beat_clr : 3'b000;
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0; in_serr = 1'b0; in_perr = 1'b0; irq_clr = 3'b000;
      if (is_err) begin
        string r = (kind == 1) ? "R6" : "R7";
        exp_irq |= (kind == 1) ? 3'b001 : 3'b010;
        chk(tgt_stop == 1'b1, r, 64'(tgt_stop), 64'd1);
        chk(commit == 1'b0, r, 64'(commit), 64'd0);
        chk(fifo_empty == 1'b1, r, 64'(fifo_empty), 64'd1);
        chk(drain_abort == (kind == 2), "R7", 64'(drain_abort), 64'(kind == 2));
        fin = 1;
      end else begin
        sent[n] = d;
        n++;
        exp_irq |= bev_expect(i, len, part_at);
        if (lst || n == DEPTH) begin
          chk(commit == 1'b1, "R2", 64'(commit), 64'd1);
          chk(commit_addr == a, "R2", 64'(commit_addr), 64'(a));
          chk(commit_words == CW'(n), "R2", 64'(commit_words), 64'(n));
          chk(tgt_stop == !lst, "R3", 64'(tgt_stop), 64'(!lst));
          words = n;
          fin = 1;
        end else begin
          chk(commit == 1'b0 && tgt_stop == 1'b0, "R2", {62'd0, commit, tgt_stop}, 64'd0);
        end
      end
    end
    chk(irq_flags == exp_irq, "R8", 64'(irq_flags), 64'(exp_irq));
  endtask

  task automatic clear_all();
    @(negedge clk);
    irq_clr = 3'b111;
    @(negedge clk);
    irq_clr = 3'b000;
    exp_irq = 3'b000;
    chk(irq_flags == 3'b000, "R9", 64'(irq_flags), 64'd0);
  endtask

  task automatic drain(input int n, input bit probe);
    drain_busy = 1'b1;
    if (probe && n > 0) begin
      // ignored beats after a refused start must not reach the FIFO
      start_req(32'hDEAD_0000, 1'b1, "R4");
      @(negedge clk);
      in_valid = 1'b1; in_data = 32'hBAD0_BAD0; in_be = 4'hF; in_last = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      chk(commit == 1'b0, "R4", 64'(commit), 64'd0);
    end
    for (int k = 0; k < n; k++) begin
      chk(fifo_empty == 1'b0, "R10", 64'(fifo_empty), 64'd0);
      chk(rd_data == sent[k], "R10", 64'(rd_data), 64'(sent[k]));
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
    end
    chk(fifo_empty == 1'b1, "R10", 64'(fifo_empty), 64'd1);
    if (probe) start_req(32'hDEAD_0004, 1'b1, "R4");
    drain_busy = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int w;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    in_start = 0; in_addr = '0; in_valid = 0; in_data = '0; in_be = '0; in_last = 0;
    in_serr = 0; in_perr = 0; drain_busy = 0; drain_rearb = 0; rd_en = 0; irq_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fifo_empty == 1'b1, "R1", 64'(fifo_empty), 64'd1);
    chk({tgt_retry, tgt_stop, commit, drain_abort} == 4'b0, "R1",
        64'({tgt_retry, tgt_stop, commit, drain_abort}), 64'd0);
    chk(irq_flags == 3'b000, "R1", 64'(irq_flags), 64'd0);

    // R2 plain burst, R4 refusal while buffered, R10 drain order
    run_burst(32'h1000_0000, 4, -1, 0, -1, w);
    drain(w, 1'b1);
    // R3 exact fill with last, then overlong burst cut at DEPTH
    run_burst(32'h1000_0100, DEPTH, -1, 0, -1, w);
    drain(w, 1'b0);
    run_burst(32'h1000_0200, DEPTH + 4, -1, 0, -1, w);
    drain(w, 1'b0);
    // R4 busy alone with an empty FIFO
    drain_busy = 1'b1;
    start_req(32'h2000_0000, 1'b1, "R4");
    drain_busy = 1'b0;
    // R5 rearbitration retry with empty FIFO
    drain_rearb = 1'b1;
    start_req(32'h2000_0010, 1'b1, "R5");
    drain_rearb = 1'b0;
    // R6 system error mid burst, flag raised while a clear is held (R9 set wins)
    beat_clr = 3'b001;
    run_burst(32'h3000_0000, 6, 2, 1, -1, w);
    beat_clr = 3'b000;
    run_burst(32'h3000_0040, 2, -1, 0, -1, w);
    drain(w, 1'b0);
    // R7 parity error at beat 3
    run_burst(32'h3000_0080, 6, 3, 2, -1, w);
    // R9 clear only the system error bit
    @(negedge clk);
    irq_clr = 3'b001;
    @(negedge clk);
    irq_clr = 3'b000;
    exp_irq = 3'b010;
    chk(irq_flags == 3'b010, "R9", 64'(irq_flags), 64'd2);
    clear_all();
    // R8 single-beat partial: no flag; multi-beat partial: flag, data intact
    run_burst(32'h4000_0000, 1, -1, 0, 0, w);
    chk(irq_flags[2] == 1'b0, "R8", 64'(irq_flags[2]), 64'd0);
    drain(w, 1'b0);
    run_burst(32'h4000_0040, 5, -1, 0, 2, w);
    chk(irq_flags[2] == 1'b1, "R8", 64'(irq_flags[2]), 64'd1);
    drain(w, 1'b0);
    clear_all();
    // error on the beat that would have filled the FIFO
    run_burst(32'h4000_0080, DEPTH + 2, DEPTH - 1, 1, -1, w);
    clear_all();

    // random mix
    for (int it = 0; it < 60; it++) begin
      int len = 1 + int'($urandom % (DEPTH + 4));
      int kind = ($urandom % 4 == 0) ? 1 + int'($urandom % 2) : 0;
      int eat = int'($urandom % len);
      int pat = ($urandom % 3 == 0) ? int'($urandom % len) : -1;
      run_burst({$urandom} & 32'hFFFF_FFFC, len, eat, kind, pat, w);
      drain(w, ($urandom % 2) == 1);
      clear_all();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule